// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the 15-bit program counter of a small byte-oriented processor and works out the address it moves to on each executed instruction. The instruction decoder supplies a mode code and the instruction's target fields. The block then advances to the next byte, or takes one of four kinds of jump: a short signed relative jump, an absolute jump inside the current 4K segment, an absolute jump anywhere in the 32K space, or an indirect jump through a table in program memory.

The indirect jump takes two cycles. In the cycle after it is accepted, the block raises `busy_o` and points `fetch_o` at a table entry. The entry's address uses the upper program counter bits for the high part and the accumulator for the low byte. At the end of that cycle the byte returned on `tbl_i` becomes the new low byte of the counter. In every other cycle `fetch_o` follows the counter. The block assumes one-byte instructions: the sequential successor is always the counter plus one.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` and `fetch_o` read 0 and `busy_o` reads 0.
- R2: With `en_i` high, not busy, and mode code 0 (sequential), the counter becomes pc+1 at the next clock edge. The value 0x7FFF wraps to 0x0000.
- R3: With `en_i` low and not busy, the counter keeps its value, whatever the mode and fields are.
- R4: Mode code 1 (relative) loads pc+1+d, taken modulo 2^15. Here d is `rel_i` read as a 6-bit two's-complement number (−32..+31). This gives a reach of −31..+32 from the jump's own address, with no restriction at 256-byte or 4K boundaries.
- R5: A relative jump with `rel_i` = 0 (+1 from the jump's address) gives the same result as a sequential step.
- R6: Mode code 2 (absolute) loads {pc[14:12], `abs_seg_i`[11:0]}, so bits 14:12 are kept.
- R7: Mode code 3 (absolute long) loads `abs_long_i`, replacing all 15 bits.
- R8: Mode code 4 (indirect) leaves the counter unchanged at the accepting edge. During the following single cycle, `busy_o` is 1 and `fetch_o` = {pc[14:8], accumulator byte sampled at acceptance}.
- R9: At the edge that ends the busy cycle, the counter becomes {pc[14:8], `tbl_i`} and `busy_o` returns to 0. The values of `en_i`, `mode_i` and the target fields in the busy cycle have no effect.
- R10: Mode codes 5, 6 and 7 act as a sequential step.
- R11: Whenever `busy_o` is 0, `fetch_o` equals `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| en_i | input | 1 | Execute the presented instruction at this edge |
| mode_i | input | 3 | Next-address mode code |
| rel_i | input | 6 | Signed relative displacement |
| abs_seg_i | input | 12 | In-segment absolute target |
| abs_long_i | input | 15 | Full absolute target |
| acc_i | input | 8 | Accumulator, low byte of the table address |
| tbl_i | input | 8 | Table byte read from program memory in the busy cycle |
| pc_o | output | 15 | Program counter |
| fetch_o | output | 15 | Program-memory fetch address |
| busy_o | output | 1 | Indirect table-read cycle in progress |

## Verification
The assertions assume that program memory returns the table byte on `tbl_i` within the busy cycle, for the address shown on `fetch_o`. They also assume that `rst_ni` is released in step with the clock. The stimulus drives every input just after a rising edge and sets `tbl_i` before the edge that ends each busy cycle. In that busy cycle it also drives an unrelated jump with `en_i` high, so that a busy cycle that wrongly accepts input becomes visible.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;
  typedef enum logic [2:0] {
    MODE_SEQ  = 3'd0,
    MODE_REL  = 3'd1,
    MODE_ABS  = 3'd2,
    MODE_LONG = 3'd3,
    MODE_IND  = 3'd4
  } pcnu_mode_e;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_TBL = 1'b1
  } pcnu_state_e;
endpackage

// File: rtl/pcnu_target.sv
module pcnu_target
  import pcnu_pkg::*;
#(
  parameter int PC_W  = 15,
  parameter int SEG_W = 12,
  parameter int REL_W = 6
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [2:0]       mode_i,
  input  logic [REL_W-1:0] rel_i,
  input  logic [SEG_W-1:0] abs_seg_i,
  input  logic [PC_W-1:0]  abs_long_i,
  output logic [PC_W-1:0]  tgt_o,
  output logic             ind_req_o
);
  localparam int EXT_W = PC_W - REL_W;

  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] rel_ext;
  logic [PC_W-1:0] rel_addr;
  logic [PC_W-1:0] seg_addr;

  assign seq_addr = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
  assign rel_ext  = {{EXT_W{rel_i[REL_W-1]}}, rel_i};
  assign rel_addr = seq_addr + rel_ext;

  generate
    if (SEG_W < PC_W) begin : g_seg
      assign seg_addr = {pc_i[PC_W-1:SEG_W], abs_seg_i};
    end else begin : g_flat
      assign seg_addr = abs_seg_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    ind_req_o = 1'b0;
    case (mode_i)
      MODE_REL:  tgt_o = rel_addr;
      MODE_ABS:  tgt_o = seg_addr;
      MODE_LONG: tgt_o = abs_long_i;
      MODE_IND: begin
        tgt_o     = pc_i;
        ind_req_o = 1'b1;
      end
      default:   tgt_o = seq_addr;
    endcase
  end
endmodule

// File: rtl/pcnu_ctrl.sv
module pcnu_ctrl
  import pcnu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ind_req_i,
  input  logic [BYTE_W-1:0] acc_i,
  output logic              busy_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] acc_q_o
);
  pcnu_state_e state_q, state_d;
  logic              acc_en;
  logic [BYTE_W-1:0] acc_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    acc_en  = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (en_i) begin
          if (ind_req_i) begin
            state_d = ST_TBL;
            acc_en  = 1'b1;
          end else begin
            load_o = 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_RUN;
        load_o  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (acc_en) acc_q <= acc_i;
  end

  assign busy_o  = (state_q == ST_TBL);
  assign acc_q_o = acc_q;

  // R8
  tbl_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  // R8
  tbl_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && en_i && ind_req_i) |=> busy_o);
endmodule

// File: rtl/pcnu_pcreg.sv
module pcnu_pcreg #(
  parameter int PC_W = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PC_W-1:0] d_i,
  output logic [PC_W-1:0] q_o
);
  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (load_i) pc_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign q_o = pc_q;

  // R3
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcnu_pkg::*;
#(
  parameter int PC_W   = 15,
  parameter int SEG_W  = 12,
  parameter int REL_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        mode_i,
  input  logic [REL_W-1:0]  rel_i,
  input  logic [SEG_W-1:0]  abs_seg_i,
  input  logic [PC_W-1:0]   abs_long_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] tbl_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   fetch_o,
  output logic              busy_o
);
  localparam int HI_W = PC_W - BYTE_W;

  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   tgt;
  logic [PC_W-1:0]   pc_d;
  logic              ind_req;
  logic              load;
  logic              busy;
  logic [BYTE_W-1:0] acc_q;
  logic [HI_W-1:0]   pc_hi;

  assign pc_hi = pc[PC_W-1:BYTE_W];

  pcnu_target #(.PC_W(PC_W), .SEG_W(SEG_W), .REL_W(REL_W)) u_target (
    .pc_i       (pc),
    .mode_i     (mode_i),
    .rel_i      (rel_i),
    .abs_seg_i  (abs_seg_i),
    .abs_long_i (abs_long_i),
    .tgt_o      (tgt),
    .ind_req_o  (ind_req)
  );

  pcnu_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ind_req_i (ind_req),
    .acc_i     (acc_i),
    .busy_o    (busy),
    .load_o    (load),
    .acc_q_o   (acc_q)
  );

  always_comb begin
    if (busy) pc_d = {pc_hi, tbl_i};
    else      pc_d = tgt;
  end

  pcnu_pcreg #(.PC_W(PC_W)) u_pcreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (pc_d),
    .q_o    (pc)
  );

  assign pc_o    = pc;
  assign busy_o  = busy;
  assign fetch_o = busy ? {pc_hi, acc_q} : pc;

  // R8
  ind_pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(pc_o));

  // R9
  ind_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (pc_o == {$past(pc_o[PC_W-1:BYTE_W]), $past(tbl_i)}));

  // R7
  long_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && en_i && mode_i == MODE_LONG) |=> (pc_o == $past(abs_long_i)));

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && en_i && mode_i == MODE_SEQ) |=> (pc_o == $past(pc_o) + 1'b1));

  generate
    if (SEG_W < PC_W) begin : g_seg_chk
      // R6
      abs_seg_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && en_i && mode_i == MODE_ABS)
          |=> (pc_o[PC_W-1:SEG_W] == $past(pc_o[PC_W-1:SEG_W])));
    end
  endgenerate
endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        en_i;
  logic [2:0]  mode_i;
  logic [5:0]  rel_i;
  logic [11:0] abs_seg_i;
  logic [14:0] abs_long_i;
  logic [7:0]  acc_i;
  logic [7:0]  tbl_i;
  logic [14:0] pc_o;
  logic [14:0] fetch_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pc_next_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .rel_i(rel_i), .abs_seg_i(abs_seg_i), .abs_long_i(abs_long_i),
    .acc_i(acc_i), .tbl_i(tbl_i), .pc_o(pc_o), .fetch_o(fetch_o),
    .busy_o(busy_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic op(logic [2:0] m, logic [5:0] r, logic [11:0] a12,
                    logic [14:0] a15, logic [7:0] acc, logic en = 1'b1);
    en_i = en; mode_i = m; rel_i = r; abs_seg_i = a12;
    abs_long_i = a15; acc_i = acc;
    @(posedge clk_i); #1;
  endtask

  task automatic go(logic [14:0] a);
    op(3'd3, 6'd0, 12'd0, a, 8'd0);
  endtask

  function automatic logic [14:0] rel_exp(logic [14:0] pc, logic [5:0] r);
    logic [14:0] d;
    d = {{9{r[5]}}, r};
    return pc + 15'd1 + d;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0; en_i = 1'b1; mode_i = 3'd3; rel_i = 0;
    abs_seg_i = 0; abs_long_i = 15'h1234; acc_i = 0; tbl_i = 0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 pc", pc_o, 0);
    check("R1 fetch", fetch_o, 0);
    check("R1 busy", busy_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_seq();
    go(15'h7FFE);
    check("R7 long", pc_o, 15'h7FFE);
    op(3'd0, 0, 0, 0, 0);
    check("R2 step", pc_o, 15'h7FFF);
    check("R11 fetch", fetch_o, 15'h7FFF);
    op(3'd0, 0, 0, 0, 0);
    check("R2 wrap", pc_o, 15'h0000);
  endtask

  task automatic t_hold();
    go(15'h2222);
    op(3'd3, 0, 0, 15'h1111, 0, 1'b0);
    check("R3 hold long", pc_o, 15'h2222);
    op(3'd4, 0, 0, 0, 8'h55, 1'b0);
    check("R3 hold ind", pc_o, 15'h2222);
    check("R3 no busy", busy_o, 0);
  endtask

  task automatic t_rel();
    logic [14:0] s [5] = '{15'h10FF, 15'h0FFE, 15'h1000, 15'h0005, 15'h2345};
    logic [5:0]  r [5] = '{6'h1F, 6'h1F, 6'h20, 6'h20, 6'h00};
    for (int i = 0; i < 5; i++) begin
      go(s[i]);
      op(3'd1, r[i], 0, 0, 0);
      check(i == 4 ? "R5 rel zero" : "R4 rel", pc_o, rel_exp(s[i], r[i]));
    end
    go(15'h1000);
    op(3'd1, 6'h20, 0, 0, 0);
    check("R4 reach -31", pc_o, 15'h0FE1);
    go(15'h10FF);
    op(3'd1, 6'h1F, 0, 0, 0);
    check("R4 reach +32", pc_o, 15'h111F);
  endtask

  task automatic t_abs();
    go(15'h5ABC);
    op(3'd2, 0, 12'h123, 15'h7777, 0);
    check("R6 abs", pc_o, 15'h5123);
    go(15'h7FFF);
    op(3'd2, 0, 12'h000, 0, 0);
    check("R6 abs top seg", pc_o, 15'h7000);
    go(15'h0000);
    op(3'd2, 0, 12'hABC, 0, 0);
    check("R6 abs seg0", pc_o, 15'h0ABC);
  endtask

  task automatic t_long();
    go(15'h0123);
    op(3'd3, 6'h3F, 12'hFFF, 15'h6543, 0);
    check("R7 long", pc_o, 15'h6543);
  endtask

  task automatic t_ind(logic [14:0] s, logic [7:0] acc, logic [7:0] tb);
    go(s);
    op(3'd4, 6'h1F, 12'h0FF, 15'h7ABC, acc);
    check("R8 busy", busy_o, 1);
    check("R8 pc held", pc_o, s);
    check("R8 fetch", fetch_o, {s[14:8], acc});
    tbl_i = tb;
    op(3'd3, 6'h05, 12'h111, 15'h0707, 8'h99);
    check("R9 pc", pc_o, {s[14:8], tb});
    check("R9 busy clr", busy_o, 0);
    check("R11 fetch", fetch_o, {s[14:8], tb});
    tbl_i = 8'h00;
  endtask

  task automatic t_unused();
    for (int m = 5; m < 8; m++) begin
      go(15'h4100);
      op(3'(m), 6'h10, 12'h222, 15'h0333, 0);
      check("R10 unused", pc_o, 15'h4101);
    end
  endtask

  initial begin
    t_reset();
    t_seq();
    t_hold();
    t_rel();
    t_abs();
    t_long();
    t_ind(15'h3456, 8'hC3, 8'h0F);
    t_ind(15'h12FF, 8'h00, 8'hFF);
    t_ind(15'h7F00, 8'hFF, 8'h80);
    t_unused();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule